// File: doc/BRIEF.md
# Sixteen-Times Interpolation Filter Chain

This block raises a stream of 10-bit signed PCM samples to sixteen times their arrival rate, ready to feed a noise-shaping modulator. It runs entirely on the oversampled clock. The chain has three stages. First comes a short symmetric FIR that pre-emphasises the band edge, so that the droop added by the last stage is offset. Next, a 7-tap halfband filter doubles the rate. Last, a third-order cascaded integrator-comb section multiplies the rate by eight. The first two stages build every coefficient product from shifted copies of the operand joined by adders and subtractors. No multiplier is used anywhere.

Sample pacing comes from a two-state controller and a 16-step phase counter. In `S_FILL` the block holds its input ready high and waits for the first sample. The transition `first_take` (a valid input seen in `S_FILL`) moves the controller to `S_RUN`, which it leaves only through reset. The self-loop `slot_advance` keeps it in `S_RUN`. While running, one input slot opens every 16 cycles. Every cycle then carries one output sample. If a slot closes with no valid input, the chain takes a zero.

Top module: `interp_chain`

## Requirements
- R1: During and straight after reset, in_ready is 1, out_valid is 0 and out_data is 0.
- R2: In the fill state in_ready stays 1 and out_valid stays 0. The first cycle with in_valid high takes sample s0 (call it cycle 0). From cycle 1 onward, out_valid is 1 on every cycle.
- R3: After the first take, in_ready is 1 exactly on cycles 16k (k ≥ 1) and 0 on all other cycles.
- R4: in_data and in_valid offered in a cycle with in_ready low have no effect on out_data.
- R5: A slot whose ready cycle has in_valid low contributes the sample value 0.
- R6: The first stage computes y[k] = -s[k] + 10·s[k-1] - s[k-2] at the input rate.
- R7: The second stage zero-stuffs y by two and applies taps (-1, 0, 9, 16, 9, 0, -1). Even output 2k is -y[k]+9y[k-1]+9y[k-2]-y[k-3]. Odd output 2k+1 is 16·y[k-1].
- R8: The third stage has three comb and three integrator sections, rate 8 and differential delay 1. Its response equals a zero-stuff by 8 followed by the cube of an 8-sample boxcar (22 taps). Halfband output 2k enters at cycle 16k+3 and output 2k+1 enters at cycle 16k+11.
- R9: out_data in cycle t is the boxcar sum over stuffed inputs up to cycle t-4, shifted right arithmetically by 13 and clamped to [-512, 511].
- R10: A constant input c settles to out_data = c (unity DC gain), including the full-scale values 511 and -512.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampled-rate clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input sample offered |
| in_ready | output | 1 | Input slot open this cycle |
| in_data | input | 10 | Signed input sample |
| out_valid | output | 1 | Output sample strobe |
| out_data | output | 10 | Signed interpolated sample |

## Verification
The checker watches the handshake and the strobe on every cycle. It checks that in_ready is held while filling and that the strobe never drops once running. It also checks that a slot opens once and then stays closed for exactly 15 cycles, and that the output is zero before the first take. The arithmetic (the FIR and halfband taps, the boxcar response, the 13-bit scaling and the clamp) can only be shown by the bench's scenarios. These compare every output sample against a direct-form convolution model under impulse, full-scale steps, alternating and ramped patterns, missing slots and junk data offered outside open slots.

// File: rtl/interp_pkg.sv
package interp_pkg;
    typedef enum logic {
        S_FILL = 1'b0,
        S_RUN  = 1'b1
    } run_state_t;

    localparam int COMP_GAIN_BITS = 3;  // first stage DC gain 8
    localparam int HB_GAIN_BITS   = 4;  // halfband DC gain 16 per phase
endpackage

// File: rtl/comp_fir.sv
module comp_fir #(
    parameter int IN_W = 10
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   load,
    input  logic signed [IN_W-1:0] din,
    output logic signed [IN_W+3:0] y
);
    localparam int Y_W = IN_W + 4;

    logic signed [IN_W-1:0] xq [3];
    logic signed [Y_W-1:0]  e0, e1, e2;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 3; i++) xq[i] <= '0;
        end else if (load) begin
            xq[0] <= din;
            xq[1] <= xq[0];
            xq[2] <= xq[1];
        end
    end

    assign e0 = Y_W'(xq[0]);
    assign e1 = Y_W'(xq[1]);
    assign e2 = Y_W'(xq[2]);

    // 10 = 8 + 2 as shifted terms; outer taps are -1
    assign y = (e1 <<< 3) + (e1 <<< 1) - e0 - e2;
endmodule

// File: rtl/halfband_interp.sv
module halfband_interp #(
    parameter int Y_W  = 14,
    parameter int HB_W = 19
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  shift,
    input  logic                  odd,
    input  logic signed [Y_W-1:0] din,
    output logic signed [HB_W-1:0] dout
);
    localparam int TAPS = 4;

    logic signed [HB_W-1:0] yl [TAPS];
    logic signed [HB_W-1:0] even_sum, odd_sum;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < TAPS; i++) yl[i] <= '0;
        end else if (shift) begin
            yl[0] <= HB_W'(din);
            for (int i = 1; i < TAPS; i++) yl[i] <= yl[i-1];
        end
    end

    // even branch: taps -1, 9, 9, -1 with 9 = 8 + 1
    assign even_sum = (yl[1] <<< 3) + yl[1] + (yl[2] <<< 3) + yl[2] - yl[0] - yl[3];
    // odd branch: centre tap only, a delayed copy scaled by 16
    assign odd_sum  = yl[1] <<< 4;
    assign dout     = odd ? odd_sum : even_sum;
endmodule

// File: rtl/cic_interp.sv
module cic_interp #(
    parameter int IN_W   = 19,
    parameter int STAGES = 3,
    parameter int RATE   = 8,
    parameter int ACC_W  = IN_W + STAGES * $clog2(RATE)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    comb_en,
    input  logic                    stuff,
    input  logic signed [IN_W-1:0]  din,
    output logic signed [ACC_W-1:0] acc
);
    logic signed [ACC_W-1:0] cv [STAGES+1];
    logic signed [ACC_W-1:0] cd [STAGES];
    logic signed [ACC_W-1:0] iv [STAGES];
    logic signed [ACC_W-1:0] comb_q;

    assign cv[0] = ACC_W'(din);

    for (genvar g = 0; g < STAGES; g++) begin : g_comb
        assign cv[g+1] = cv[g] - cd[g];
        always_ff @(posedge clk) begin
            if (!rst_n)       cd[g] <= '0;
            else if (comb_en) cd[g] <= cv[g];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)       comb_q <= '0;
        else if (comb_en) comb_q <= cv[STAGES];
    end

    for (genvar g = 0; g < STAGES; g++) begin : g_integ
        if (g == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (!rst_n)     iv[g] <= '0;
                else if (stuff) iv[g] <= iv[g] + comb_q;
            end
        end else begin : g_rest
            always_ff @(posedge clk) begin
                if (!rst_n) iv[g] <= '0;
                else        iv[g] <= iv[g] + iv[g-1];
            end
        end
    end

    assign acc = iv[STAGES-1];
endmodule

// File: rtl/interp_chain.sv
module interp_chain
    import interp_pkg::*;
#(
    parameter int IN_W       = 10,
    parameter int OUT_W      = 10,
    parameter int CIC_RATE   = 8,
    parameter int CIC_STAGES = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [IN_W-1:0]  in_data,
    output logic             out_valid,
    output logic [OUT_W-1:0] out_data
);
    localparam int PERIOD = 2 * CIC_RATE;
    localparam int PH_W   = $clog2(PERIOD);
    localparam int Y_W    = IN_W + 4;
    localparam int HB_W   = Y_W + 5;
    localparam int ACC_W  = HB_W + CIC_STAGES * $clog2(CIC_RATE);
    localparam int SHIFT  = COMP_GAIN_BITS + HB_GAIN_BITS + (CIC_STAGES - 1) * $clog2(CIC_RATE);

    localparam logic [PH_W-1:0] PH_TAKE  = PH_W'(0);
    localparam logic [PH_W-1:0] PH_SHIFT = PH_W'(1);
    localparam logic [PH_W-1:0] PH_EVEN  = PH_W'(2);
    localparam logic [PH_W-1:0] PH_ODD   = PH_W'(2 + CIC_RATE);
    localparam logic [PH_W-1:0] PH_LAST  = PH_W'(PERIOD - 1);

    localparam logic signed [ACC_W-1:0] HI_LIM = ACC_W'((2 ** (OUT_W - 1)) - 1);
    localparam logic signed [ACC_W-1:0] LO_LIM = -HI_LIM - ACC_W'(1);

    run_state_t state_q, state_d;
    logic [PH_W-1:0] ph_q;
    logic load_x, hb_shift, comb_en, hb_odd, stuff, ph_run;
    logic signed [IN_W-1:0]  x_in;
    logic signed [Y_W-1:0]   comp_y;
    logic signed [HB_W-1:0]  hb_y;
    logic signed [ACC_W-1:0] acc, scaled;
    logic signed [OUT_W-1:0] out_q;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_FILL;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_FILL: if (in_valid) state_d = S_RUN;  // first_take
            S_RUN:  state_d = S_RUN;                // slot_advance
        endcase
    end

    always_comb begin
        in_ready  = 1'b0;
        out_valid = 1'b0;
        load_x    = 1'b0;
        ph_run    = 1'b0;
        hb_shift  = 1'b0;
        comb_en   = 1'b0;
        hb_odd    = 1'b0;
        stuff     = 1'b0;
        unique case (state_q)
            S_FILL: begin
                in_ready = 1'b1;
                load_x   = in_valid;
                ph_run   = in_valid;
            end
            S_RUN: begin
                out_valid = 1'b1;
                ph_run    = 1'b1;
                in_ready  = (ph_q == PH_TAKE);
                load_x    = (ph_q == PH_TAKE);
                hb_shift  = (ph_q == PH_SHIFT);
                comb_en   = (ph_q == PH_EVEN) || (ph_q == PH_ODD);
                hb_odd    = (ph_q == PH_ODD);
                stuff     = (ph_q == PH_EVEN + PH_W'(1)) || (ph_q == PH_ODD + PH_W'(1));
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)      ph_q <= '0;
        else if (ph_run) ph_q <= (ph_q == PH_LAST) ? '0 : ph_q + PH_W'(1);
    end

    assign x_in = in_valid ? $signed(in_data) : '0;

    comp_fir #(.IN_W(IN_W)) u_comp (
        .clk(clk), .rst_n(rst_n), .load(load_x), .din(x_in), .y(comp_y)
    );

    halfband_interp #(.Y_W(Y_W), .HB_W(HB_W)) u_hb (
        .clk(clk), .rst_n(rst_n), .shift(hb_shift), .odd(hb_odd),
        .din(comp_y), .dout(hb_y)
    );

    cic_interp #(.IN_W(HB_W), .STAGES(CIC_STAGES), .RATE(CIC_RATE), .ACC_W(ACC_W)) u_cic (
        .clk(clk), .rst_n(rst_n), .comb_en(comb_en), .stuff(stuff),
        .din(hb_y), .acc(acc)
    );

    assign scaled = acc >>> SHIFT;

    always_ff @(posedge clk) begin
        if (!rst_n)                out_q <= '0;
        else if (scaled > HI_LIM)  out_q <= HI_LIM[OUT_W-1:0];
        else if (scaled < LO_LIM)  out_q <= LO_LIM[OUT_W-1:0];
        else                       out_q <= scaled[OUT_W-1:0];
    end

    assign out_data = out_q;
endmodule

// File: rtl/interp_chain_chk.sv
module interp_chain_chk #(
    parameter int OUT_W    = 10,
    parameter int CIC_RATE = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic             in_ready,
    input logic             out_valid,
    input logic [OUT_W-1:0] out_data
);
    localparam int PERIOD = 2 * CIC_RATE;
    localparam int GAP_W  = $clog2(PERIOD) + 1;

    logic [GAP_W-1:0] gap;

    always_ff @(posedge clk) begin
        if (!rst_n)                      gap <= '0;
        else if (in_ready)               gap <= '0;
        else if (gap != {GAP_W{1'b1}})   gap <= gap + GAP_W'(1);
    end

    AST_FILL_READY: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> in_ready);  // R2
    AST_STROBE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> out_valid);  // R2
    AST_START_ON_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid) |-> $past(in_valid));  // R2
    AST_SLOT_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && in_ready) |=> !in_ready);  // R3
    AST_SLOT_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(out_valid) && in_ready) |-> (gap == GAP_W'(PERIOD - 1)));  // R3
    AST_QUIET_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (out_data == '0));  // R1
endmodule

bind interp_chain interp_chain_chk #(.OUT_W(OUT_W), .CIC_RATE(CIC_RATE)) u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .out_valid(out_valid), .out_data(out_data)
);

// File: tb/test_interp_chain.sv
module test_interp_chain;
    localparam int IN_W = 10;
    localparam int OUT_W = 10;
    localparam int MAXS = 64;
    localparam int BOXL = 22;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic in_ready;
    logic [IN_W-1:0] in_data = '0;
    logic out_valid;
    logic [OUT_W-1:0] out_data;

    int checks = 0;
    int failures = 0;
    int smp [MAXS];
    bit pres [MAXS];
    int ns = 0;
    longint box3 [BOXL];

    always #4 clk = ~clk;

    interp_chain i_interp_chain (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_data(in_data), .out_valid(out_valid), .out_data(out_data)
    );

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic longint s_at(input int k);
        if (k < 0 || k >= ns) return 0;
        return pres[k] ? longint'(smp[k]) : 0;
    endfunction

    function automatic longint y_at(input int k);  // R6
        return -s_at(k) + 10 * s_at(k - 1) - s_at(k - 2);
    endfunction

    function automatic longint hb_at(input int n);  // R7: direct form on stuffed sequence
        longint h [7] = '{-1, 0, 9, 16, 9, 0, -1};
        longint sum = 0;
        for (int j = 0; j < 7; j++) begin
            int m = n - j;
            if (m >= 0 && (m % 2) == 0) sum += h[j] * y_at(m / 2);
        end
        return sum;
    endfunction

    function automatic longint hz_at(input int u);  // R8 entry timing
        if (u < 3) return 0;
        if (((u - 3) % 8) != 0) return 0;
        return hb_at((u - 3) / 8);
    endfunction

    function automatic longint model_out(input int t);  // R9
        longint sum = 0;
        longint v;
        for (int j = 0; j < BOXL; j++) sum += box3[j] * hz_at(t - 4 - j);
        v = sum >>> 13;
        if (v > 511) v = 511;
        if (v < -512) v = -512;
        return v;
    endfunction

    function automatic longint sx(input logic [OUT_W-1:0] d);
        return longint'($signed(d));
    endfunction

    task automatic do_reset();
        rst_n = 1'b0;
        in_valid = 1'b0;
        repeat (3) @(negedge clk);
        chk(in_ready == 1'b1, "R1 in_ready in reset", in_ready, 1);
        chk(out_valid == 1'b0, "R1 out_valid in reset", out_valid, 0);
        chk(out_data == '0, "R1 out_data in reset", sx(out_data), 0);
        rst_n = 1'b1;
    endtask

    // Runs one stream from reset; every output sample is compared with the model.
    task automatic run_seq(input int fill_wait, input int junk);
        do_reset();
        for (int w = 0; w < fill_wait; w++) begin
            @(negedge clk);
            chk(in_ready == 1'b1, "R2 ready while filling", in_ready, 1);
            chk(out_valid == 1'b0, "R2 no strobe while filling", out_valid, 0);
            in_valid = 1'b0;
            in_data = IN_W'($urandom);
        end
        @(negedge clk);
        chk(in_ready == 1'b1, "R2 ready at first take", in_ready, 1);
        chk(out_valid == 1'b0, "R2 strobe low at first take", out_valid, 0);
        in_valid = 1'b1;
        in_data = IN_W'(smp[0]);
        for (int t = 1; t <= ns * 16 + 40; t++) begin
            @(negedge clk);
            chk(out_valid == 1'b1, "R2 strobe every cycle", out_valid, 1);
            chk(in_ready == ((t % 16) == 0), "R3 slot cadence", in_ready, ((t % 16) == 0));
            chk(sx(out_data) == model_out(t), "R6 R7 R8 R9 R4 R5 sample", sx(out_data), model_out(t));
            if ((t % 16) == 0) begin
                int k = t / 16;
                in_valid = (k < ns) && pres[k];
                in_data = in_valid ? IN_W'(smp[k]) : IN_W'($urandom);
            end else begin
                in_valid = junk[0];
                in_data = IN_W'($urandom);
            end
            if (t == ns * 16 - 1 && junk > 1)
                chk(sx(out_data) == longint'(smp[0]), "R10 settled DC", sx(out_data), smp[0]);
        end
        in_valid = 1'b0;
    endtask

    task automatic fill_const(input int n, input int v);
        ns = n;
        for (int i = 0; i < n; i++) begin smp[i] = v; pres[i] = 1'b1; end
    endtask

    task automatic t_reset();
        do_reset();
        @(negedge clk);
        chk(out_valid == 1'b0, "R1 idle after reset", out_valid, 0);
        chk(out_data == '0, "R1 output zero after reset", sx(out_data), 0);
    endtask

    task automatic t_impulse();
        ns = 8;
        for (int i = 0; i < ns; i++) begin smp[i] = 0; pres[i] = 1'b1; end
        smp[0] = 256;
        run_seq(5, 0);
    endtask

    task automatic t_pos_step();
        fill_const(12, 511);
        run_seq(0, 2);
    endtask

    task automatic t_neg_step();
        fill_const(12, -512);
        run_seq(2, 2);
    endtask

    task automatic t_alternate();
        ns = 16;
        for (int i = 0; i < ns; i++) begin smp[i] = (i % 2) ? -300 : 300; pres[i] = 1'b1; end
        run_seq(1, 1);
    endtask

    task automatic t_ramp();
        ns = 20;
        for (int i = 0; i < ns; i++) begin smp[i] = -480 + 50 * i; pres[i] = 1'b1; end
        run_seq(0, 0);
    endtask

    task automatic t_gaps();
        ns = 16;
        for (int i = 0; i < ns; i++) begin
            smp[i] = 200 - 37 * i;
            pres[i] = (i == 0) || ((i % 3) != 1);
        end
        run_seq(3, 1);
    endtask

    initial begin
        longint b1 [8];
        longint b2 [15];
        for (int i = 0; i < 8; i++) b1[i] = 1;
        for (int i = 0; i < 15; i++) begin
            b2[i] = 0;
            for (int j = 0; j < 8; j++) if (i - j >= 0 && i - j < 8) b2[i] += b1[j];
        end
        for (int i = 0; i < BOXL; i++) begin
            box3[i] = 0;
            for (int j = 0; j < 8; j++) if (i - j >= 0 && i - j < 15) box3[i] += b2[i - j];
        end
        t_reset();
        t_impulse();
        t_pos_step();
        t_neg_step();
        t_alternate();
        t_ramp();
        t_gaps();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL R2 watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule